// File: doc/BRIEF.md
# Link Pulse Generator and Integrity Monitor

This block belongs to a 10 Mb/s twisted-pair transceiver. While the transmitter is quiet, it sends a short pulse on the line at a fixed spacing so that the far end can tell the cable is connected. Whenever transmit data is present, no pulses are sent. The spacing timer starts again each time the transmitter goes idle, so the first pulse always comes a fixed time after the end of a frame.

In the other direction, the block watches a strobe that marks each valid received link pulse or receive activity. It raises a link-good flag, which the rest of the transceiver uses to enable its transmit, receive and collision paths. The flag drops when the strobe has been silent for a whole timeout window, and one strobe is enough to raise it again. When integrity checking is switched off, the link is treated as good and the link LED stays lit. All intervals are parameters counted in clock cycles. At the nominal 10 MHz clock, the defaults give a 100 ns pulse, a 16 ms spacing and a 100 ms timeout.

Top module: `link_pulse_mon`

## Requirements
- R1: After reset, or after a clock edge that samples `tx_active` high, `lp_out` rises after exactly PERIOD_CYC consecutive clock edges that sample `tx_active` low. It rises again every PERIOD_CYC edges for as long as the line stays idle.
- R2: Each pulse on `lp_out` stays high for exactly WIDTH_CYC clock cycles, where WIDTH_CYC is smaller than PERIOD_CYC.
- R3: After any clock edge that samples `tx_active` high, `lp_out` is low. This also cuts short a pulse that is already in progress.
- R4: A clock edge that samples `rx_pulse` high makes `link_ok` high after that edge.
- R5: When `integ_off` is low, `link_ok` goes low at the TIMEOUT_CYC-th clock edge after the last edge that sampled `rx_pulse` high, provided no further strobe arrives in between. With no strobe since reset, it stays low.
- R6: While `integ_off` is high, `link_ok` and `led_link` are high in the same cycle, whatever the pulse history.
- R7: `led_link` always equals `link_ok`.
- R8: During reset and directly after it, `lp_out` is low and `link_ok` is low unless `integ_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_active | input | 1 | High while transmit data is being sent |
| rx_pulse | input | 1 | One-cycle strobe for a valid received link pulse or receive activity |
| integ_off | input | 1 | High to bypass link integrity checking |
| lp_out | output | 1 | Link pulse drive to the line driver |
| link_ok | output | 1 | Link-good flag that gates transmit, receive and collision functions |
| led_link | output | 1 | Link LED drive |

## Verification
The bench builds the block with PERIOD_CYC = 40, WIDTH_CYC = 3 and TIMEOUT_CYC = 100. These short values put several pulse repetitions and complete link timeouts inside a few hundred cycles. A three-cycle pulse makes the width counting visible, and also lets a transmit burst cut into the middle of a pulse. Because the timeout is longer than the pulse spacing, random idle stretches end both before and after the link drops.

// File: rtl/link_pulse_mon.sv
module link_pulse_mon #(
  parameter int PERIOD_CYC  = 160000,
  parameter int WIDTH_CYC   = 1,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_pulse,
  input  logic integ_off,
  output logic lp_out,
  output logic link_ok,
  output logic led_link
);

  localparam int GW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int WW = $clog2(WIDTH_CYC + 1);
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

  logic [GW-1:0] gap;
  logic [WW-1:0] wleft;
  logic [TW-1:0] quiet;
  logic          link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      wleft <= '0;
    end else if (tx_active) begin
      gap   <= '0;
      wleft <= '0;
    end else if (gap == GW'(PERIOD_CYC - 1)) begin
      gap   <= '0;
      wleft <= WW'(WIDTH_CYC);
    end else begin
      gap <= gap + GW'(1);
      if (wleft != '0) wleft <= wleft - WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet  <= '0;
      link_q <= 1'b0;
    end else if (rx_pulse) begin
      quiet  <= '0;
      link_q <= 1'b1;
    end else if (quiet == TW'(TIMEOUT_CYC - 1)) begin
      link_q <= 1'b0;
    end else begin
      quiet <= quiet + TW'(1);
    end
  end

  assign lp_out   = (wleft != '0);
  assign link_ok  = link_q | integ_off;
  assign led_link = link_ok;

endmodule

// File: rtl/link_pulse_mon_chk.sv
module link_pulse_mon_chk #(
  parameter int PERIOD_CYC  = 160000,
  parameter int WIDTH_CYC   = 1,
  parameter int TIMEOUT_CYC = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic rx_pulse,
  input logic integ_off,
  input logic lp_out,
  input logic link_ok,
  input logic led_link
);

  int hi_run;
  int since_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= 0;
      since_rx <= TIMEOUT_CYC;
    end else begin
      hi_run <= lp_out ? hi_run + 1 : 0;
      if (rx_pulse) since_rx <= 0;
      else if (since_rx < TIMEOUT_CYC) since_rx <= since_rx + 1;
    end
  end

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_out |-> hi_run < WIDTH_CYC);

  p_tx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !lp_out);

  p_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |=> link_ok);

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && !integ_off) |-> since_rx < TIMEOUT_CYC);

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    integ_off |-> (link_ok && led_link));

  p_led_r7: assert property (@(posedge clk) disable iff (!rst_n)
    led_link == link_ok);

endmodule

bind link_pulse_mon link_pulse_mon_chk #(
  .PERIOD_CYC(PERIOD_CYC),
  .WIDTH_CYC(WIDTH_CYC),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tx_active(tx_active),
  .rx_pulse(rx_pulse),
  .integ_off(integ_off),
  .lp_out(lp_out),
  .link_ok(link_ok),
  .led_link(led_link)
);

// File: tb/link_pulse_mon_tb.sv
module link_pulse_mon_tb;
  localparam int P = 40;
  localparam int W = 3;
  localparam int T = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic rx_pulse = 1'b0;
  logic integ_off = 1'b0;
  logic lp_out, link_ok, led_link;

  int total = 0;
  int bad = 0;
  int idle_n = 0;
  int since = 0;
  bit ever = 1'b0;
  bit last_tx = 1'b0;

  always #2 clk = ~clk;

  link_pulse_mon #(.PERIOD_CYC(P), .WIDTH_CYC(W), .TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
    .integ_off(integ_off), .lp_out(lp_out), .link_ok(link_ok), .led_link(led_link)
  );

  function automatic bit exp_lp(int n);
    return (n >= P) && ((n % P) < W);
  endfunction

  function automatic bit exp_link(bit byp, bit seen, int s);
    return byp || (seen && s < T);
  endfunction

  task automatic chk(string tag, bit act, bit exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit el;
    bit ek;
    el = exp_lp(idle_n);
    ek = exp_link(integ_off, ever, since);
    chk(last_tx ? "R3" : (el ? "R2" : "R1"), lp_out, el, "lp_out");
    chk(integ_off ? "R6" : (ek ? "R4" : "R5"), link_ok, ek, "link_ok");
    chk("R7", led_link, link_ok, "led_link");
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      idle_n = 0; since = 0; ever = 1'b0; last_tx = 1'b0;
    end else begin
      last_tx = tx_active;
      if (tx_active) idle_n = 0; else idle_n++;
      if (rx_pulse) begin since = 0; ever = 1'b1; end
      else if (since < T) since++;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) step();
    chk("R8", lp_out, 1'b0, "reset lp_out");
    chk("R8", link_ok, 1'b0, "reset link_ok");
    integ_off = 1'b1;
    #1;
    chk("R8", link_ok, 1'b1, "reset link_ok bypass");
    chk("R6", led_link, 1'b1, "reset led bypass");
    integ_off = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R8", lp_out, 1'b0, "post-reset lp_out");
    chk("R8", link_ok, 1'b0, "post-reset link_ok");

    // R1 R2: idle through three pulse periods
    repeat (3 * P + 5) step();
    // R3: transmit cuts into a pulse
    repeat (P - 5 - 1) step();
    tx_active = 1'b1; step(); step();
    tx_active = 1'b0;
    repeat (P + 2) step();
    tx_active = 1'b1; step();
    tx_active = 1'b0;
    repeat (P + W + 2) step();
    // R4 R5: one strobe, then full timeout
    rx_pulse = 1'b1; step(); rx_pulse = 1'b0;
    repeat (T + 5) step();
    // strobe just before timeout keeps link up
    rx_pulse = 1'b1; step(); rx_pulse = 1'b0;
    repeat (T - 2) step();
    rx_pulse = 1'b1; step(); rx_pulse = 1'b0;
    repeat (T + 2) step();
    // R6: bypass with link down, then released
    integ_off = 1'b1; repeat (10) step();
    integ_off = 1'b0; repeat (3) step();

    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      int len;
      bit txmode;
      txmode = ($urandom % 3) == 0;
      len = txmode ? 1 + ($urandom % 30) : 1 + ($urandom % 150);
      if (($urandom % 5) == 0) integ_off = ~integ_off;
      tx_active = txmode;
      for (int i = 0; i < len; i++) begin
        rx_pulse = (($urandom % 70) == 0);
        step();
      end
      rx_pulse = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule